// File: doc/BRIEF.md
# Integer to Extended-Float Stack Loader

This block takes a two's-complement integer that is 16, 32 or 64 bits wide and turns it into an 80-bit extended-precision floating-point value. Every integer in that range fits exactly, so the conversion has no rounding step. The block then pushes the value onto an eight-entry register stack.

The push is a pre-decrement: the 3-bit stack pointer moves down by one, modulo 8, and the new value lands in the entry the pointer now selects. Each entry carries a 2-bit tag. When a push targets an entry that already holds data, the block flags a stack fault on the C1 condition flag and raises a stack-exception pulse.

The fault behaviour depends on whether the invalid exception is masked. When it is masked, the push still happens and stores the negative quiet-NaN indefinite value. When it is unmasked, the stack is left as it was. A combinational read port shows any entry and its tag, so the caller can inspect the stack.

Top module: `int_fp_stack_loader`

## Requirements
- R1: `size_i` selects the operand width. 2'b00 takes bits 15:0, 2'b01 takes bits 31:0, and 2'b10 or 2'b11 take all 64 bits. The block sign-extends the selected field and ignores the operand bits above it.
- R2: The 80-bit result places the sign at bit 79, a 15-bit exponent biased by 16383 at bits 78:64, and a 64-bit significand with an explicit integer bit at bits 63:0. A nonzero result has bit 63 set, and its value is exactly significand × 2^(exponent − 16383 − 63).
- R3: The sign bit of the result equals the sign of the selected integer.
- R4: A zero operand produces all 80 bits zero, and the destination entry is tagged 2'b01 (zero).
- R5: The most negative 64-bit integer gives sign 1, exponent 0x403E and significand 0x8000000000000000.
- R6: After reset, the stack pointer is 0, every entry is tagged 2'b11 (empty), every entry holds 0, and `c1_o`, `stk_exc_o` and `done_o` are 0. A push without fault decrements the pointer modulo 8, writes the value into the entry the new pointer selects, and tags that entry 2'b00 (valid), or 2'b01 if the value is zero.
- R7: A push whose target entry is not tagged empty is a stack fault. A fault sets `c1_o` to 1 and pulses `stk_exc_o` with `done_o`. A push without fault clears `c1_o` to 0 and leaves `stk_exc_o` low.
- R8: On a fault with `inv_mask_i`=1, the pointer is still decremented. The target entry receives 0xFFFF_C000000000000000 and is tagged 2'b00, and `result_o` shows that value.
- R9: On a fault with `inv_mask_i`=0, the pointer and every stack entry and tag stay unchanged.
- R10: `done_o` is a one-cycle pulse in the cycle after each `start_i`. `result_o` and `c1_o` hold their values until the next push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Push strobe, one cycle |
| size_i | input | 2 | Operand width select |
| operand_i | input | 64 | Integer operand |
| inv_mask_i | input | 1 | Invalid exception masked when 1 |
| rd_idx_i | input | 3 | Stack entry select for the read port |
| rd_data_o | output | 80 | Value of the selected entry |
| rd_tag_o | output | 2 | Tag of the selected entry |
| top_o | output | 3 | Stack pointer |
| result_o | output | 80 | Value of the last push |
| c1_o | output | 1 | Stack-fault condition flag |
| stk_exc_o | output | 1 | Stack exception pulse |
| done_o | output | 1 | Push complete pulse |

## Verification
The following properties are checked on every cycle:
- the done pulse follows each strobe by exactly one cycle;
- C1 agrees with the exception pulse;
- the pointer moves by one on a push that is allowed;
- nonzero results come out normalised;
- a write never leaves an entry tagged empty.

Other behaviour only shows up in the bench scenarios, which compare every cycle against a behavioural model:
- exact values for particular operands, such as the most negative quadword and the ignored upper operand bits on narrow sizes;
- the pointer wrapping through all eight entries;
- the stored indefinite value;
- an unmasked fault leaving the stack untouched.

// File: rtl/fild_pkg.sv
package fild_pkg;
  localparam int EXP_W    = 15;
  localparam int SIG_W    = 64;
  localparam int FP_W     = 1 + EXP_W + SIG_W;
  localparam int EXP_BIAS = 16383;

  typedef enum logic [1:0] {
    SZ_WORD   = 2'b00,
    SZ_DWORD  = 2'b01,
    SZ_QWORD  = 2'b10,
    SZ_QWORD2 = 2'b11
  } int_size_e;

  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tag_e;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [SIG_W-1:0] sig;
  } ext_fp_t;

  localparam ext_fp_t FP_INDEF = '{sign: 1'b1, exp: {EXP_W{1'b1}},
                                   sig: {2'b11, {(SIG_W-2){1'b0}}}};
endpackage

// File: rtl/int_operand_fmt.sv
module int_operand_fmt
  import fild_pkg::*;
#(
  parameter int IN_W = 64
) (
  input  logic [IN_W-1:0] operand_i,
  input  logic [1:0]      size_i,
  output logic            neg_o,
  output logic [IN_W-1:0] mag_o
);
  logic [IN_W-1:0] sext_w;

  always_comb begin
    unique case (int_size_e'(size_i))
      SZ_WORD:  sext_w = {{(IN_W-16){operand_i[15]}}, operand_i[15:0]};
      SZ_DWORD: sext_w = {{(IN_W-32){operand_i[31]}}, operand_i[31:0]};
      default:  sext_w = operand_i;
    endcase
  end

  assign neg_o = sext_w[IN_W-1];
  // unsigned view of -min is still exact
  assign mag_o = neg_o ? (~sext_w + 1'b1) : sext_w;
endmodule

// File: rtl/lzc64.sv
module lzc64 #(
  parameter int W  = 64,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  output logic [CW-1:0] cnt_o,
  output logic          zero_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) begin
      if (data_i[i]) cnt_o = CW'(W - 1 - i);
    end
  end
  assign zero_o = ~|data_i;
endmodule

// File: rtl/fp_normalize.sv
module fp_normalize
  import fild_pkg::*;
(
  input  logic             neg_i,
  input  logic [SIG_W-1:0] mag_i,
  output ext_fp_t          fp_o,
  output logic             zero_o
);
  localparam int CW = $clog2(SIG_W);
  logic [CW-1:0] lz_w;
  logic          z_w;

  lzc64 #(.W(SIG_W)) u_lzc (.data_i(mag_i), .cnt_o(lz_w), .zero_o(z_w));

  always_comb begin
    if (z_w) begin
      fp_o = '0;
    end else begin
      fp_o.sign = neg_i;
      fp_o.exp  = EXP_W'(EXP_BIAS + SIG_W - 1) - EXP_W'(lz_w);
      fp_o.sig  = mag_i << lz_w;
    end
  end
  assign zero_o = z_w;

  always_comb begin
    if (!$isunknown(mag_i) && mag_i != '0)
      AST_NORM_MSB: assert (fp_o.sig[SIG_W-1]); // R2
  end
endmodule

// File: rtl/fp_stack_file.sv
module fp_stack_file
  import fild_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  ext_fp_t       wdata_i,
  input  tag_e          wtag_i,
  input  logic [AW-1:0] raddr_i,
  output ext_fp_t       rdata_o,
  output tag_e          rtag_o,
  input  logic [AW-1:0] paddr_i,
  output tag_e          ptag_o
);
  ext_fp_t data_q [DEPTH];
  tag_e    tag_q  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_q[g] <= '0;
        tag_q[g]  <= TAG_EMPTY;
      end else if (we_i && waddr_i == AW'(g)) begin
        data_q[g] <= wdata_i;
        tag_q[g]  <= wtag_i;
      end
    end
  end

  assign rdata_o = data_q[raddr_i];
  assign rtag_o  = tag_q[raddr_i];
  assign ptag_o  = tag_q[paddr_i];

  AST_WRITE_TAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> tag_q[$past(waddr_i)] != TAG_EMPTY); // R6
endmodule

// File: rtl/int_fp_stack_loader.sv
module int_fp_stack_loader
  import fild_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    size_i,
  input  logic [63:0]   operand_i,
  input  logic          inv_mask_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [79:0]   rd_data_o,
  output logic [1:0]    rd_tag_o,
  output logic [AW-1:0] top_o,
  output logic [79:0]   result_o,
  output logic          c1_o,
  output logic          stk_exc_o,
  output logic          done_o
);
  logic             neg_w, zero_w, ovf_w, push_w;
  logic [SIG_W-1:0] mag_w;
  ext_fp_t          conv_w, wdata_w, rdata_w;
  tag_e             wtag_w, rtag_w, ptag_w;
  logic [AW-1:0]    top_q, top_nxt_w;
  ext_fp_t          res_q;
  logic             c1_q, exc_q, done_q;

  int_operand_fmt #(.IN_W(SIG_W)) u_fmt (
    .operand_i(operand_i), .size_i(size_i), .neg_o(neg_w), .mag_o(mag_w));

  fp_normalize u_norm (.neg_i(neg_w), .mag_i(mag_w), .fp_o(conv_w), .zero_o(zero_w));

  assign top_nxt_w = top_q - AW'(1);
  assign ovf_w     = ptag_w != TAG_EMPTY;
  assign push_w    = start_i && (!ovf_w || inv_mask_i);
  assign wdata_w   = ovf_w ? FP_INDEF : conv_w;
  assign wtag_w    = (!ovf_w && zero_w) ? TAG_ZERO : TAG_VALID;

  fp_stack_file #(.DEPTH(DEPTH)) u_stk (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(push_w), .waddr_i(top_nxt_w), .wdata_i(wdata_w), .wtag_i(wtag_w),
    .raddr_i(rd_idx_i), .rdata_o(rdata_w), .rtag_o(rtag_w),
    .paddr_i(top_nxt_w), .ptag_o(ptag_w));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q  <= '0;
      res_q  <= '0;
      c1_q   <= 1'b0;
      exc_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= start_i;
      exc_q  <= start_i && ovf_w;
      if (start_i) begin
        c1_q  <= ovf_w;
        res_q <= wdata_w;
      end
      if (push_w) top_q <= top_nxt_w;
    end
  end

  assign rd_data_o = rdata_w;
  assign rd_tag_o  = rtag_w;
  assign top_o     = top_q;
  assign result_o  = res_q;
  assign c1_o      = c1_q;
  assign stk_exc_o = exc_q;
  assign done_o    = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o); // R10
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o); // R10
  AST_C1_EXC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (c1_o == stk_exc_o)); // R7
  AST_TOP_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !ovf_w) |=> top_o == $past(top_o) - AW'(1)); // R6
  AST_UNMASKED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ovf_w && !inv_mask_i) |=> $stable(top_o)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(result_o) && $stable(c1_o) && $stable(top_o))); // R10
endmodule

// File: tb/int_fp_stack_loader_tb_top.sv
module int_fp_stack_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  size = 2'b00;
  logic [63:0] op = '0;
  logic        mask = 1'b1;
  logic [2:0]  rd_idx = '0;
  logic [79:0] rd_data, result;
  logic [1:0]  rd_tag;
  logic [2:0]  top;
  logic        c1, exc, done;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  int_fp_stack_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .size_i(size), .operand_i(op),
    .inv_mask_i(mask), .rd_idx_i(rd_idx), .rd_data_o(rd_data), .rd_tag_o(rd_tag),
    .top_o(top), .result_o(result), .c1_o(c1), .stk_exc_o(exc), .done_o(done));

  // reference model
  logic [79:0] m_reg [8];
  logic [1:0]  m_tag [8];
  logic [2:0]  m_top;
  logic [79:0] m_res;
  logic        m_c1, m_exc, m_done;

  function automatic logic [79:0] ref_conv(logic [1:0] sz, logic [63:0] v);
    longint      s;
    logic [63:0] m;
    int          msb;
    case (sz)
      2'b00:   s = longint'(shortint'(v[15:0]));
      2'b01:   s = longint'(int'(v[31:0]));
      default: s = longint'(v);
    endcase
    if (s == 0) return '0;
    m = (s < 0) ? 64'(-s) : 64'(s);
    msb = 0;
    for (int i = 0; i < 64; i++) if (m[i]) msb = i;
    return {s < 0, 15'(16383 + msb), m << (63 - msb)};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_reg[i] = '0; m_tag[i] = 2'b11; end
      m_top = 0; m_res = '0; m_c1 = 0; m_exc = 0; m_done = 0;
    end else begin
      m_done = start;
      m_exc  = 0;
      if (start) begin
        logic [2:0]  t;
        logic [79:0] v;
        logic        f;
        t = m_top - 3'd1;
        f = m_tag[t] != 2'b11;
        v = ref_conv(size, op);
        m_c1 = f; m_exc = f;
        if (f) begin
          m_res = 80'hFFFF_C000_0000_0000_0000;
          if (mask) begin m_reg[t] = m_res; m_tag[t] = 2'b00; m_top = t; end
        end else begin
          m_res = v; m_reg[t] = v; m_tag[t] = (v == '0) ? 2'b01 : 2'b00; m_top = t;
        end
      end
    end
  end

  task automatic chk(bit ok, string req, logic [79:0] act, logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle compare on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(done === m_done, "R10 done", 80'(done), 80'(m_done));
      chk(exc === m_exc, "R7 stk_exc", 80'(exc), 80'(m_exc));
      chk(c1 === m_c1, "R7 c1", 80'(c1), 80'(m_c1));
      chk(top === m_top, "R6 top", 80'(top), 80'(m_top));
      chk(result === m_res, "R2 result", result, m_res);
      chk(rd_data === m_reg[rd_idx], "R6 rd_data", rd_data, m_reg[rd_idx]);
      chk(rd_tag === m_tag[rd_idx], "R6 rd_tag", 80'(rd_tag), 80'(m_tag[rd_idx]));
    end
  end

  initial begin
    forever begin
      @(posedge clk); #3;
      rd_idx = rd_idx + 3'd1;
    end
  end

  task automatic push(logic [1:0] sz, logic [63:0] v, logic mk);
    @(posedge clk); #2;
    start = 1; size = sz; op = v; mask = mk;
    @(posedge clk); #2;
    start = 0; op = 64'hDEAD_BEEF_0BAD_F00D;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    join_none
    #35 rst_n = 1;
    @(negedge clk);
    chk(top === 3'd0 && done === 0 && c1 === 0 && exc === 0, "R6 reset", 80'(top), 80'd0);
    idle(9);
    push(2'b10, 64'd1, 1);
    chk(result === 80'h3FFF_8000_0000_0000_0000, "R2 one", result, 80'h3FFF_8000_0000_0000_0000);
    push(2'b10, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    chk(result === 80'hBFFF_8000_0000_0000_0000, "R3 minus one", result, 80'hBFFF_8000_0000_0000_0000);
    push(2'b00, 64'h1234_5678_9ABC_8000, 1);
    chk(result === 80'hC00E_8000_0000_0000_0000, "R1 word -32768", result, 80'hC00E_8000_0000_0000_0000);
    push(2'b01, 64'hFFFF_FFFF_7FFF_FFFF, 1);
    chk(result === 80'h401D_FFFF_FFFE_0000_0000, "R1 dword max", result, 80'h401D_FFFF_FFFE_0000_0000);
    idle(3);
    push(2'b01, 64'hABCD_0000_0000_0000, 0);
    chk(result === 80'h0 && top === 3'd3, "R4 zero", result, 80'h0);
    push(2'b10, 64'h8000_0000_0000_0000, 1);
    chk(result === 80'hC03E_8000_0000_0000_0000, "R5 min64", result, 80'hC03E_8000_0000_0000_0000);
    push(2'b11, 64'h7FFF_FFFF_FFFF_FFFF, 0);
    push(2'b00, 64'h0000_0000_0000_0005, 0);
    chk(top === 3'd0, "R6 wrap", 80'(top), 80'd0);
    idle(8);
    push(2'b10, 64'd42, 0);
    chk(c1 === 1 && exc === 1 && top === 3'd0, "R9 unmasked fault", 80'(top), 80'd0);
    idle(8);
    push(2'b10, 64'd42, 1);
    chk(c1 === 1 && result === 80'hFFFF_C000_0000_0000_0000 && top === 3'd7,
        "R8 masked fault", result, 80'hFFFF_C000_0000_0000_0000);
    idle(2);
    chk(c1 === 1 && done === 0 && exc === 0, "R10 hold", 80'(c1), 80'd1);
    idle(8);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule